// File: doc/BRIEF.md
# Byte-Run Compressor for a Parallel Host Transmit Path

This block sits between a producer of payload bytes and the logic that drives a bidirectional parallel port. It accepts payload bytes over a valid/ready handshake and hands out bytes over a second valid/ready handshake. Every output byte carries a tag that marks it as a command or as data. When compression is on, a stretch of identical payload bytes becomes one command that holds a repeat count, followed by one copy of the byte. A lone byte goes out as plain data with no command in front of it.

Command bytes share one space. If the top bit is clear, the low seven bits are a repeat count. If the top bit is set, the low seven bits select a channel. A requester can ask for a channel-select command at any time. The block inserts it only at a run boundary, so it never lands between a count and the byte that count applies to.

A last-byte marker on the input makes the block emit the open run at once. Clearing the compress-enable input turns every accepted byte into an uncompressed data byte.

Top module: `rle_compressor`

## Requirements
- R1: A run of N identical accepted bytes, with 2 <= N <= RUN_LIMIT (default 128), goes out as two bytes. First comes a command byte (out_cmd=1) whose bit 7 is 0 and whose bits 6:0 equal N-1. Then comes one data byte (out_cmd=0) equal to the repeated value.
- R2: A byte that is not repeated goes out as one data byte only, with no count command. A count command never carries the value 0.
- R3: A run longer than RUN_LIMIT is split into pieces. Each full piece goes out as count RUN_LIMIT-1 plus the byte. The remainder follows under the rules of R1 or R2.
- R4: When a byte differs from the open run, the open run is emitted in full before anything derived from the new byte.
- R5: An accepted byte with in_last=1 closes the run it belongs to. That run is emitted with no further input needed.
- R6: A byte accepted while compress_en=0 goes out as a data byte (out_cmd=0) on its own, even when it equals its neighbours.
- R7: A channel request goes out as a command byte {1'b1, chan_addr}. chan_ack is high for exactly the cycle in which that byte is handed over.
- R8: A channel command is never placed between a count command and its data byte. A request made while a run is open goes out right after that run's data byte. A request made while idle is served before any new input is accepted.
- R9: While out_valid=1 and out_ready=0, out_valid stays high and out_data and out_cmd keep their values.
- R10: After reset, out_valid=0, in_ready=1 and chan_ack=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| compress_en | input | 1 | 1: merge runs; 0: pass each byte through as data |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte can be taken this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Close the run after this byte |
| chan_req | input | 1 | Request to insert a channel-select command; hold until acknowledged |
| chan_addr | input | 7 | Channel number; stable while chan_req is high |
| chan_ack | output | 1 | Channel command handed over this cycle |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_cmd | output | 1 | 1: command byte, 0: data byte |

## Verification
The run counter and the stored byte feed the output byte directly, so state errors show up at the port. A counter that is off by one or wraps wrong shows up as a count command with the wrong value in the same cycle the run is emitted, which is one cycle after the closing input. A wrong compare or a lost staging register shows up as a missing, extra or out-of-order byte in the output stream. The scoreboard catches this at the next handover. A sequencing fault places a channel command inside a count/data pair, and the checker flags the cycle after the count is handed over. Stall behaviour is checked on every cycle in which out_ready is low.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int RLE_BYTE_W  = 8;
    localparam int RLE_FIELD_W = RLE_BYTE_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // no run open
        ST_HOLD = 3'd1,  // run open, still collecting
        ST_CNT  = 3'd2,  // presenting the count command
        ST_DAT  = 3'd3,  // presenting the run's data byte
        ST_ADR  = 3'd4   // presenting a channel command
    } rle_state_e;

    typedef struct packed {
        rle_state_e              st;
        logic [RLE_BYTE_W-1:0]   run_byte;
        logic [RLE_FIELD_W-1:0]  run_cnt;    // repeats beyond the first
        logic                    stg_vld;    // byte waiting behind the run
        logic [RLE_BYTE_W-1:0]   stg_byte;
        logic                    stg_close;  // waiting byte closes at once
    } rle_regs_t;
endpackage

// File: rtl/rle_run_match.sv
module rle_run_match
    import rle_pkg::*;
#(
    parameter int RUN_LIMIT = 128
) (
    input  logic                   enable,
    input  logic [RLE_BYTE_W-1:0]  run_byte,
    input  logic [RLE_FIELD_W-1:0] run_cnt,
    input  logic [RLE_BYTE_W-1:0]  new_byte,
    output logic                   extend
);
    localparam logic [RLE_FIELD_W-1:0] CNT_TOP = RLE_FIELD_W'(RUN_LIMIT - 1);

    logic same_value;
    logic has_room;

    always_comb begin
        same_value = (new_byte == run_byte);
        has_room   = (run_cnt < CNT_TOP);
        extend     = enable && same_value && has_room;
    end
endmodule

// File: rtl/rle_emit_mux.sv
module rle_emit_mux
    import rle_pkg::*;
(
    input  rle_state_e             st,
    input  logic [RLE_FIELD_W-1:0] run_cnt,
    input  logic [RLE_BYTE_W-1:0]  run_byte,
    input  logic [RLE_FIELD_W-1:0] chan_addr,
    output logic                   emit_valid,
    output logic [RLE_BYTE_W-1:0]  emit_data,
    output logic                   emit_cmd
);
    always_comb begin
        emit_valid = 1'b0;
        emit_data  = '0;
        emit_cmd   = 1'b0;
        unique case (st)
            ST_CNT: begin
                emit_valid = 1'b1;
                emit_data  = {1'b0, run_cnt};
                emit_cmd   = 1'b1;
            end
            ST_DAT: begin
                emit_valid = 1'b1;
                emit_data  = run_byte;
            end
            ST_ADR: begin
                emit_valid = 1'b1;
                emit_data  = {1'b1, chan_addr};
                emit_cmd   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rle_compressor.sv
module rle_compressor
    import rle_pkg::*;
#(
    parameter int RUN_LIMIT = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   compress_en,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [RLE_BYTE_W-1:0]  in_data,
    input  logic                   in_last,
    input  logic                   chan_req,
    input  logic [RLE_FIELD_W-1:0] chan_addr,
    output logic                   chan_ack,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [RLE_BYTE_W-1:0]  out_data,
    output logic                   out_cmd
);
    localparam rle_regs_t REGS_RST = '{
        st: ST_IDLE, run_byte: '0, run_cnt: '0,
        stg_vld: 1'b0, stg_byte: '0, stg_close: 1'b0
    };

    rle_regs_t r_q, r_d;
    logic      extend;
    logic      close_in;
    logic      take;

    rle_run_match #(.RUN_LIMIT(RUN_LIMIT)) u_match (
        .enable   (compress_en),
        .run_byte (r_q.run_byte),
        .run_cnt  (r_q.run_cnt),
        .new_byte (in_data),
        .extend   (extend)
    );

    rle_emit_mux u_emit (
        .st         (r_q.st),
        .run_cnt    (r_q.run_cnt),
        .run_byte   (r_q.run_byte),
        .chan_addr  (chan_addr),
        .emit_valid (out_valid),
        .emit_data  (out_data),
        .emit_cmd   (out_cmd)
    );

    always_comb begin
        in_ready = ((r_q.st == ST_IDLE) && !chan_req) || (r_q.st == ST_HOLD);
        take     = out_valid && out_ready;
        chan_ack = (r_q.st == ST_ADR) && out_ready;
        close_in = in_last || !compress_en;
    end

    // Next state: one place, one struct.
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (chan_req) begin
                    r_d.st = ST_ADR;
                end else if (in_valid) begin
                    r_d.run_byte = in_data;
                    r_d.run_cnt  = '0;
                    r_d.st       = close_in ? ST_DAT : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (in_valid) begin
                    if (extend) begin
                        r_d.run_cnt = r_q.run_cnt + 1'b1;
                        r_d.st      = in_last ? ST_CNT : ST_HOLD;
                    end else begin
                        r_d.stg_vld   = 1'b1;
                        r_d.stg_byte  = in_data;
                        r_d.stg_close = close_in;
                        r_d.st        = (r_q.run_cnt != '0) ? ST_CNT : ST_DAT;
                    end
                end
            end
            ST_CNT: begin
                if (take) r_d.st = ST_DAT;
            end
            ST_DAT, ST_ADR: begin
                if (take) begin
                    if ((r_q.st == ST_DAT) && chan_req) begin
                        r_d.st = ST_ADR;
                    end else if (r_q.stg_vld) begin
                        r_d.run_byte = r_q.stg_byte;
                        r_d.run_cnt  = '0;
                        r_d.stg_vld  = 1'b0;
                        r_d.st       = r_q.stg_close ? ST_DAT : ST_HOLD;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/rle_compressor_chk.sv
module rle_compressor_chk #(
    parameter int RUN_LIMIT = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [6:0] chan_addr,
    input logic       chan_ack,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_cmd
);
    // R9: a stalled byte holds still
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_cmd));

    // R1 / R8: a count handed over is followed directly by its data byte
    a_r1_count_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_cmd && !out_data[7] |=> out_valid && !out_cmd);

    // R2 / R3: count field never zero and never above the limit
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cmd && !out_data[7] |->
            (out_data[6:0] != 7'd0) && (out_data[6:0] <= 7'(RUN_LIMIT - 1)));

    // R7: acknowledge marks the handover of the channel command
    a_r7_ack_matches: assert property (@(posedge clk) disable iff (!rst_n)
        chan_ack |-> out_valid && out_ready && out_cmd && (out_data == {1'b1, chan_addr}));

    // R8: input is never taken while a channel command is presented
    a_r8_addr_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cmd && out_data[7] |-> !in_ready);
endmodule

bind rle_compressor rle_compressor_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .chan_addr (chan_addr),
    .chan_ack  (chan_ack),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_cmd   (out_cmd)
);

// File: tb/rle_compressor_bench.sv
module rle_compressor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       compress_en = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       chan_req = 1'b0;
    logic [6:0] chan_addr = '0;
    logic       chan_ack;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_cmd;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic stall_on = 1'b1;
    logic ack_seen = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    rle_compressor u_rle_compressor (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic cmd, input logic [7:0] b, input string req);
        exp_q.push_back({cmd, b});
        tag_q.push_back(req);
    endtask

    // called just after a falling edge
    task automatic push(input logic [7:0] b, input logic last);
        in_valid = 1'b1; in_data = b; in_last = last;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic drain(input string req);
        int w = 0;
        while (exp_q.size() != 0 && w < 2000) begin @(negedge clk); w++; end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0 && !out_valid, req, exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
    endtask

    // downstream ready pattern, changed away from the sampling edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_ready = !stall_on || ((cyc % 3) != 1);
    end

    // scoreboard monitor and stall checker
    logic       prev_stall = 1'b0;
    logic [8:0] prev_byte = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)   // R9
                check(out_valid && ({out_cmd, out_data} == prev_byte), "R9",
                      {out_valid, out_cmd, out_data}, {1'b1, prev_byte});
            prev_stall = out_valid && !out_ready;
            prev_byte  = {out_cmd, out_data};
            if (chan_ack) ack_seen = 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 (unexpected byte)", {out_cmd, out_data}, 0);
                end else begin
                    automatic logic [8:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check({out_cmd, out_data} == e, t, {out_cmd, out_data}, e);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check(!out_valid, "R10 out_valid", out_valid, 0);
        check(in_ready,   "R10 in_ready",  in_ready, 1);
        check(!chan_ack,  "R10 chan_ack",  chan_ack, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: 25 copies of 0x41
        expect_byte(1, 8'd24, "R1"); expect_byte(0, 8'h41, "R1");
        for (int i = 0; i < 25; i++) push(8'h41, i == 24);
        drain("R1 drain");

        // R2: lone byte
        expect_byte(0, 8'h37, "R2");
        push(8'h37, 1'b1);
        drain("R2 drain");

        // R4 / R2: mixed sequence 5,5,9,7,7,7
        expect_byte(1, 8'd1, "R4"); expect_byte(0, 8'h05, "R4");
        expect_byte(0, 8'h09, "R2 mid");
        expect_byte(1, 8'd2, "R4"); expect_byte(0, 8'h07, "R4");
        push(8'h05, 0); push(8'h05, 0); push(8'h09, 0);
        push(8'h07, 0); push(8'h07, 0); push(8'h07, 1);
        drain("R4 drain");

        // R3: 300 copies -> 127,127,43
        for (int k = 0; k < 2; k++) begin
            expect_byte(1, 8'd127, "R3"); expect_byte(0, 8'hAA, "R3");
        end
        expect_byte(1, 8'd43, "R3"); expect_byte(0, 8'hAA, "R3");
        for (int i = 0; i < 300; i++) push(8'hAA, i == 299);
        drain("R3 drain");

        // R3: 129 copies -> 127 pair then lone data byte
        expect_byte(1, 8'd127, "R3 edge"); expect_byte(0, 8'h55, "R3 edge");
        expect_byte(0, 8'h55, "R3 edge remainder");
        for (int i = 0; i < 129; i++) push(8'h55, i == 128);
        drain("R3 edge drain");

        // R5: closing byte flushes without further input, no stalls
        stall_on = 1'b0;
        expect_byte(1, 8'd3, "R5"); expect_byte(0, 8'h11, "R5");
        for (int i = 0; i < 4; i++) push(8'h11, i == 3);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 flush latency", exp_q.size(), 0);
        drain("R5 drain");
        stall_on = 1'b1;

        // R6: bypass, identical bytes stay separate data bytes
        compress_en = 1'b0;
        for (int i = 0; i < 3; i++) expect_byte(0, 8'h22, "R6");
        for (int i = 0; i < 3; i++) push(8'h22, 0);
        drain("R6 drain");
        compress_en = 1'b1;

        // R7: channel command while idle
        ack_seen = 1'b0;
        expect_byte(1, 8'h85, "R7");
        chan_addr = 7'h05; chan_req = 1'b1;
        #1;
        while (!chan_ack) begin @(negedge clk); #1; end
        @(posedge clk); #1 chan_req = 1'b0;
        drain("R7 drain");
        check(ack_seen, "R7 ack", ack_seen, 1);

        // R8: request during an open run goes after that run's data byte
        ack_seen = 1'b0;
        expect_byte(1, 8'd2, "R8"); expect_byte(0, 8'h42, "R8");
        expect_byte(1, 8'hFF, "R8 addr"); expect_byte(0, 8'h43, "R8");
        push(8'h42, 0); push(8'h42, 0); push(8'h42, 0);
        chan_addr = 7'h7F; chan_req = 1'b1;
        fork
            begin
                #1;
                while (!chan_ack) begin @(negedge clk); #1; end
                @(posedge clk); #1 chan_req = 1'b0;
            end
        join_none
        push(8'h43, 1'b1);
        drain("R8 drain");
        check(ack_seen && !chan_req, "R8 ack", ack_seen, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule